// File: doc/BRIEF.md
# Pipelined System Bus to Peripheral Bus Bridge

This block sits on a pipelined system bus as a slave and acts as the only master of a slow, two-phase peripheral bus. Each single read or write transfer that the system bus issues becomes one peripheral access. That access has a setup cycle, in which the select, direction and address are presented, and then an enable cycle, in which the data moves. A burst on the system bus becomes one peripheral access per beat, in beat order.

The bridge stalls the system bus by holding its ready output low until the peripheral access is over. In the same cycle that ready rises again, it returns the read data. A fixed address window of up to four equal regions is decoded into one-hot select lines, one line per peripheral. An access that falls outside the window still completes with normal timing, but no select line goes high and a read returns zero. When no access is in progress, the peripheral bus is held quiet.

Top module: `sysbus_periph_bridge`

## Requirements
- R1: After synchronous reset, pb_sel is all zero, pb_enable is 0, sb_ready_out is 1 and sb_rdata is 0.
- R2: A transfer is accepted only in a cycle where sb_sel=1, sb_ready_in=1 and sb_trans is 2'b10 (first beat) or 2'b11 (following beat). For sb_trans 2'b00 or 2'b01, or for sb_sel=0, no peripheral access starts and sb_ready_out stays 1.
- R3: Every accepted transfer produces exactly one setup cycle (a pb_sel bit high, pb_enable low) followed by exactly one enable cycle (the same pb_sel bit high, pb_enable high).
- R4: pb_addr and pb_write carry sb_addr and sb_write from the accepted cycle. pb_wdata carries sb_wdata from the cycle after acceptance. These outputs and pb_sel do not change between the setup cycle and the enable cycle.
- R5: In the cycle after an enable cycle, pb_enable is 0 and pb_sel is all zero.
- R6: sb_ready_out is 0 for exactly three cycles after the accepting clock edge (data capture, setup, enable) and is 1 in the fourth cycle.
- R7: For a read, sb_rdata in the cycle where sb_ready_out returns to 1 equals the selected peripheral's read data as sampled at the end of the enable cycle.
- R8: An address is inside the window when sb_addr[31:14] equals BASE_ADDR[31:14]. In that case peripheral k = sb_addr[13:12] gets pb_sel[k]. Peripheral k returns its read data on pb_rdata_bus[32k+31:32k].
- R9: An access outside the window keeps the timing of R6 but drives no pb_sel bit, and a read from it returns 0 on sb_rdata.
- R10: During a burst, the address of the next beat is accepted in the cycle where sb_ready_out is 1. Each beat gets its own peripheral access, in beat order.
- R11: pb_sel and pb_enable stay low in every cycle in which no access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both buses |
| rst | input | 1 | Synchronous reset, active high |
| sb_sel | input | 1 | Slave select from the system bus decoder |
| sb_addr | input | 32 | System bus address, valid in the address phase |
| sb_trans | input | 2 | Transfer type: 00 idle, 01 busy, 10 first beat, 11 following beat |
| sb_write | input | 1 | 1 = write, 0 = read |
| sb_wdata | input | 32 | Write data, valid in the cycle after the address phase |
| sb_ready_in | input | 1 | Bus-wide ready; the previous transfer is complete |
| sb_ready_out | output | 1 | Ready from this slave; low stalls the system bus |
| sb_rdata | output | 32 | Read data returned to the system bus |
| pb_addr | output | 32 | Peripheral address, latched for the whole access |
| pb_sel | output | 4 | One-hot peripheral select |
| pb_enable | output | 1 | High in the enable cycle |
| pb_write | output | 1 | Peripheral direction, 1 = write |
| pb_wdata | output | 32 | Peripheral write data |
| pb_rdata_bus | input | 128 | Read data from each peripheral, 32 bits per slot |

## Verification
A sequencer that skips or repeats a state shows up at once as a wrong stall length on sb_ready_out. It also shows up as an enable cycle without a setup cycle before it, or as pb_enable held for two cycles, all within four cycles of the accepting edge. A select register that is captured at the wrong time, or a decode error, drives the wrong pb_sel line or none at all during the very next setup cycle. A read-data register that samples in the wrong cycle returns stale or foreign data when ready rises. The directed tests cover each of these cases, plus idle and busy transfer types, an address outside the window, and a two-beat burst.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    // system bus transfer type codes
    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAPT,
        ST_SETUP,
        ST_ENABLE,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
    } xfer_t;

    function automatic logic trans_active(input logic [1:0] tr);
        return (tr == TR_NONSEQ) || (tr == TR_SEQ);
    endfunction

    function automatic logic seq_busy(input seq_state_t st);
        return (st == ST_CAPT) || (st == ST_SETUP) || (st == ST_ENABLE);
    endfunction

endpackage

// File: rtl/pbr_decode.sv
module pbr_decode
    import pbr_pkg::*;
#(
    parameter int                NSLV      = 4,
    parameter int                REGION_W  = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h8000_0000
) (
    input  logic [ADDR_W-1:REGION_W] addr_hi,
    output logic [NSLV-1:0]          hit,
    input  logic [NSLV-1:0]          rd_sel,
    input  logic [NSLV*DATA_W-1:0]   rdata_bus,
    output logic [DATA_W-1:0]        rdata
);
    localparam int IDXW = (NSLV > 1) ? $clog2(NSLV) : 1;
    localparam int HI   = REGION_W + IDXW;

    logic            in_win;
    logic [IDXW-1:0] idx;

    assign in_win = (addr_hi[ADDR_W-1:HI] == BASE_ADDR[ADDR_W-1:HI]);
    assign idx    = addr_hi[HI-1:REGION_W];

    for (genvar g = 0; g < NSLV; g++) begin : g_hit
        assign hit[g] = in_win && (idx == IDXW'(g));
    end

    // AND-OR read mux driven by the registered one-hot select
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NSLV; i++) begin
            if (rd_sel[i]) rdata = rdata | rdata_bus[i*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/pbr_seq.sv
module pbr_seq
    import pbr_pkg::*;
#(
    parameter int NSLV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sb_sel,
    input  logic [ADDR_W-1:0] sb_addr,
    input  logic [1:0]        sb_trans,
    input  logic              sb_write,
    input  logic [DATA_W-1:0] sb_wdata,
    input  logic              sb_ready_in,
    input  logic [NSLV-1:0]   dec_hit,
    input  logic [DATA_W-1:0] rd_mux,
    output logic [NSLV-1:0]   sel_q,
    output logic              sb_ready_out,
    output logic [DATA_W-1:0] sb_rdata,
    output logic [ADDR_W-1:0] pb_addr,
    output logic [NSLV-1:0]   pb_sel,
    output logic              pb_enable,
    output logic              pb_write,
    output logic [DATA_W-1:0] pb_wdata
);
    seq_state_t        state;
    xfer_t             xfer_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              can_take;
    logic              accept;

    assign can_take = (state == ST_IDLE) || (state == ST_DONE);
    assign accept   = can_take && sb_sel && sb_ready_in && trans_active(sb_trans);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            xfer_q  <= '0;
            sel_q   <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE, ST_DONE: begin
                    if (accept) begin
                        xfer_q <= '{addr: sb_addr, write: sb_write};
                        sel_q  <= dec_hit;
                        state  <= ST_CAPT;
                    end else begin
                        state  <= ST_IDLE;
                    end
                end
                ST_CAPT: begin
                    wdata_q <= sb_wdata;
                    state   <= ST_SETUP;
                end
                ST_SETUP: state <= ST_ENABLE;
                ST_ENABLE: begin
                    if (!xfer_q.write) rdata_q <= rd_mux;
                    state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign pb_sel       = ((state == ST_SETUP) || (state == ST_ENABLE)) ? sel_q : '0;
    assign pb_enable    = (state == ST_ENABLE);
    assign pb_addr      = xfer_q.addr;
    assign pb_write     = xfer_q.write;
    assign pb_wdata     = wdata_q;
    assign sb_ready_out = !seq_busy(state);
    assign sb_rdata     = rdata_q;

    // R3: an enable cycle always follows a setup cycle
    a_r3_setup_before_enable: assert property (@(posedge clk) disable iff (rst)
        pb_enable |-> ($past(|pb_sel) || $past(state == ST_SETUP)) && !$past(pb_enable));

    // R4: control and data held across setup and enable
    a_r4_stable_ctrl: assert property (@(posedge clk) disable iff (rst)
        pb_enable |-> $stable(pb_addr) && $stable(pb_write) && $stable(pb_wdata) && $stable(pb_sel));

    // R5: enable lasts one cycle and the bus drops afterwards
    a_r5_enable_drops: assert property (@(posedge clk) disable iff (rst)
        pb_enable |=> !pb_enable && (pb_sel == '0));

    // R6: the system bus is stalled while the peripheral bus is in use
    a_r6_stall_while_active: assert property (@(posedge clk) disable iff (rst)
        ((|pb_sel) || pb_enable) |-> !sb_ready_out);

    // R8: at most one peripheral selected
    a_r8_onehot_sel: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pb_sel));

    // R11: ready high means nothing in flight on the peripheral side
    a_r11_quiet_when_ready: assert property (@(posedge clk) disable iff (rst)
        sb_ready_out |-> !pb_enable && (pb_sel == '0));

endmodule

// File: rtl/sysbus_periph_bridge.sv
module sysbus_periph_bridge
    import pbr_pkg::*;
#(
    parameter int                NSLV      = 4,
    parameter int                REGION_W  = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h8000_0000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sb_sel,
    input  logic [ADDR_W-1:0]      sb_addr,
    input  logic [1:0]             sb_trans,
    input  logic                   sb_write,
    input  logic [DATA_W-1:0]      sb_wdata,
    input  logic                   sb_ready_in,
    output logic                   sb_ready_out,
    output logic [DATA_W-1:0]      sb_rdata,
    output logic [ADDR_W-1:0]      pb_addr,
    output logic [NSLV-1:0]        pb_sel,
    output logic                   pb_enable,
    output logic                   pb_write,
    output logic [DATA_W-1:0]      pb_wdata,
    input  logic [NSLV*DATA_W-1:0] pb_rdata_bus
);
    logic [NSLV-1:0]   dec_hit;
    logic [NSLV-1:0]   sel_q;
    logic [DATA_W-1:0] rd_mux;

    pbr_decode #(
        .NSLV(NSLV), .REGION_W(REGION_W), .BASE_ADDR(BASE_ADDR)
    ) u_decode (
        .addr_hi   (sb_addr[ADDR_W-1:REGION_W]),
        .hit       (dec_hit),
        .rd_sel    (sel_q),
        .rdata_bus (pb_rdata_bus),
        .rdata     (rd_mux)
    );

    pbr_seq #(.NSLV(NSLV)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .sb_sel       (sb_sel),
        .sb_addr      (sb_addr),
        .sb_trans     (sb_trans),
        .sb_write     (sb_write),
        .sb_wdata     (sb_wdata),
        .sb_ready_in  (sb_ready_in),
        .dec_hit      (dec_hit),
        .rd_mux       (rd_mux),
        .sel_q        (sel_q),
        .sb_ready_out (sb_ready_out),
        .sb_rdata     (sb_rdata),
        .pb_addr      (pb_addr),
        .pb_sel       (pb_sel),
        .pb_enable    (pb_enable),
        .pb_write     (pb_write),
        .pb_wdata     (pb_wdata)
    );

endmodule

// File: tb/sim_sysbus_periph_bridge.sv
module sim_sysbus_periph_bridge;
    localparam logic [31:0] BASE = 32'h8000_0000;

    logic         clk = 1'b0;
    logic         rst;
    logic         sb_sel;
    logic [31:0]  sb_addr;
    logic [1:0]   sb_trans;
    logic         sb_write;
    logic [31:0]  sb_wdata;
    logic         sb_ready_out;
    logic [31:0]  sb_rdata;
    logic [31:0]  pb_addr;
    logic [3:0]   pb_sel;
    logic         pb_enable;
    logic         pb_write;
    logic [31:0]  pb_wdata;
    logic [127:0] pb_rdata_bus;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sysbus_periph_bridge u0 (
        .clk(clk), .rst(rst), .sb_sel(sb_sel), .sb_addr(sb_addr), .sb_trans(sb_trans),
        .sb_write(sb_write), .sb_wdata(sb_wdata), .sb_ready_in(sb_ready_out),
        .sb_ready_out(sb_ready_out), .sb_rdata(sb_rdata), .pb_addr(pb_addr),
        .pb_sel(pb_sel), .pb_enable(pb_enable), .pb_write(pb_write),
        .pb_wdata(pb_wdata), .pb_rdata_bus(pb_rdata_bus)
    );

    // peripheral model: slot k answers with a pattern built from k and the address
    function automatic logic [31:0] periph_val(input int k, input logic [31:0] a);
        return 32'h5A00_0000 | (32'(k) << 16) | {16'h0, a[15:0]};
    endfunction

    always_comb begin
        for (int k = 0; k < 4; k++) pb_rdata_bus[k*32 +: 32] = periph_val(k, pb_addr);
    end

    // access log filled on every enable cycle
    int          en_n = 0;
    logic [31:0] log_addr [16];
    logic [31:0] log_data [16];
    logic [3:0]  log_sel  [16];
    logic        log_wr   [16];

    always @(posedge clk) begin
        if (!rst && pb_enable) begin
            log_addr[en_n % 16] <= pb_addr;
            log_data[en_n % 16] <= pb_wdata;
            log_sel[en_n % 16]  <= pb_sel;
            log_wr[en_n % 16]   <= pb_write;
            en_n <= en_n + 1;
        end
    end

    // protocol monitor sampled between edges
    logic prev_en  = 1'b0;
    logic prev_act = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (pb_enable && !(prev_act && !prev_en)) begin
                errors++;
                $display("FAIL R3 enable without setup actual=%b expected=%b", prev_act, 1'b1);
            end
            if (prev_en && (pb_enable || pb_sel != 4'b0)) begin
                errors++;
                $display("FAIL R5 bus active after enable actual=%b/%h expected=0/0", pb_enable, pb_sel);
            end
        end
        prev_en  = pb_enable;
        prev_act = pb_enable || (pb_sel != 4'b0) || (!sb_ready_out && !pb_enable);
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_xfer(input logic [31:0] a, input logic w, input logic [31:0] wd,
                           output logic [31:0] rd, output int waits);
        @(negedge clk);
        sb_sel = 1'b1; sb_trans = 2'b10; sb_addr = a; sb_write = w;
        @(negedge clk);
        sb_sel = 1'b0; sb_trans = 2'b00; sb_wdata = wd;
        waits = 0;
        while (!sb_ready_out && waits < 10) begin
            waits++;
            @(negedge clk);
        end
        rd = sb_rdata;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(pb_sel == 4'b0, "R1 sel", 32'(pb_sel), 0);
        chk(!pb_enable, "R1 enable", 32'(pb_enable), 0);
        chk(sb_ready_out, "R1 ready", 32'(sb_ready_out), 1);
        chk(sb_rdata == 0, "R1 rdata", sb_rdata, 0);
    endtask

    task automatic t_writes();
        logic [31:0] rd;
        int w;
        for (int k = 0; k < 4; k++) begin
            int n0 = en_n;
            logic [31:0] a  = BASE | (32'(k) << 12) | 32'(8 * k + 4);
            logic [31:0] wd = 32'hD0D0_0000 + 32'(k * 17);
            do_xfer(a, 1'b1, wd, rd, w);
            chk(w == 3, "R6 write stall", 32'(w), 3);
            chk(en_n == n0 + 1, "R3 one access", 32'(en_n - n0), 1);
            chk(log_sel[n0 % 16] == 4'(1 << k), "R8 select", 32'(log_sel[n0 % 16]), 32'(1 << k));
            chk(log_addr[n0 % 16] == a, "R4 address", log_addr[n0 % 16], a);
            chk(log_data[n0 % 16] == wd, "R4 wdata", log_data[n0 % 16], wd);
            chk(log_wr[n0 % 16] == 1'b1, "R4 direction", 32'(log_wr[n0 % 16]), 1);
            chk(!pb_enable && pb_sel == 0, "R5 idle after enable", 32'(pb_sel), 0);
        end
    endtask

    task automatic t_reads();
        logic [31:0] rd;
        int w;
        for (int k = 3; k >= 0; k -= 2) begin
            logic [31:0] a = BASE | (32'(k) << 12) | 32'h0000_0A5C;
            int n0 = en_n;
            do_xfer(a, 1'b0, 32'hFFFF_FFFF, rd, w);
            chk(w == 3, "R6 read stall", 32'(w), 3);
            chk(rd == periph_val(k, a), "R7 read data", rd, periph_val(k, a));
            chk(log_wr[n0 % 16] == 1'b0, "R4 read direction", 32'(log_wr[n0 % 16]), 0);
        end
    endtask

    task automatic t_outside();
        logic [31:0] rd;
        int w;
        int n0 = en_n;
        do_xfer(32'h4000_1010, 1'b0, 32'h0, rd, w);
        chk(w == 3, "R9 outside stall", 32'(w), 3);
        chk(en_n == n0 + 1, "R9 outside access", 32'(en_n - n0), 1);
        chk(log_sel[n0 % 16] == 4'b0, "R9 no select", 32'(log_sel[n0 % 16]), 0);
        chk(rd == 32'h0, "R9 outside read", rd, 0);
    endtask

    task automatic t_ignored();
        int n0 = en_n;
        logic [1:0] tr [3] = '{2'b00, 2'b01, 2'b10};
        logic       sl [3] = '{1'b1, 1'b1, 1'b0};
        for (int p = 0; p < 3; p++) begin
            @(negedge clk);
            sb_sel = sl[p]; sb_trans = tr[p]; sb_addr = BASE | 32'h1000; sb_write = 1'b1;
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                chk(sb_ready_out && pb_sel == 0 && !pb_enable, "R2 ignored transfer type",
                    {28'h0, pb_sel}, 0);
            end
        end
        sb_sel = 1'b0; sb_trans = 2'b00;
        chk(en_n == n0, "R11 no access while idle", 32'(en_n - n0), 0);
    endtask

    task automatic t_burst();
        int n0 = en_n;
        int w;
        logic [31:0] a0 = BASE | 32'h0000_1100;
        logic [31:0] a1 = BASE | 32'h0000_1104;
        @(negedge clk);
        sb_sel = 1'b1; sb_trans = 2'b10; sb_addr = a0; sb_write = 1'b1;
        @(negedge clk);
        sb_trans = 2'b11; sb_addr = a1; sb_wdata = 32'h1111_AAAA;
        w = 0;
        while (!sb_ready_out && w < 10) begin w++; @(negedge clk); end
        chk(w == 3, "R10 first beat stall", 32'(w), 3);
        @(negedge clk);
        sb_sel = 1'b0; sb_trans = 2'b00; sb_wdata = 32'h2222_BBBB;
        w = 0;
        while (!sb_ready_out && w < 10) begin w++; @(negedge clk); end
        chk(w == 3, "R10 second beat stall", 32'(w), 3);
        chk(en_n == n0 + 2, "R10 access per beat", 32'(en_n - n0), 2);
        chk(log_addr[n0 % 16] == a0 && log_data[n0 % 16] == 32'h1111_AAAA,
            "R10 beat 0", log_data[n0 % 16], 32'h1111_AAAA);
        chk(log_addr[(n0 + 1) % 16] == a1 && log_data[(n0 + 1) % 16] == 32'h2222_BBBB,
            "R10 beat 1", log_data[(n0 + 1) % 16], 32'h2222_BBBB);
    endtask

    initial begin
        rst = 1'b1; sb_sel = 1'b0; sb_addr = '0; sb_trans = 2'b00; sb_write = 1'b0; sb_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_writes();
        t_reads();
        t_outside();
        t_ignored();
        t_burst();
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule